// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. Each frame opens with a low start bit, carries the character least significant bit first, may add a parity bit, and closes with one or two high stop bits. The data length, parity mode and stop count are chosen at run time from a shared set of format inputs. These inputs are expected to stay stable while a frame is on the line.

Characters arrive over a valid/ready handshake. An external baud generator supplies a one-cycle `bit_tick` strobe, and the line moves to the next bit only on that strobe. The transmitter raises `in_ready` during the final stop bit. A character handed over at that point begins its start bit on the very next tick, so frames can follow one another with no idle gap. When no character is waiting, the line rests high.

Top module: `serial_frame_tx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `tx_line` is 1, `busy` is 0 and `in_ready` is 1. A reset during a frame abandons that frame.
- R2: A character accepted while idle (`in_valid` and `in_ready` both high on a clock edge with no tick) leaves `tx_line` high and sets `busy`. The next tick edge starts a start bit of value 0, which lasts one tick period.
- R3: Data bits follow the start bit, least significant first. The count is set by `cfg_size`: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, code 7 gives 9 bits, and codes 4, 5 and 6 give 8 bits.
- R4: `cfg_parity` 2'b10 adds an even parity bit equal to the XOR of the active data bits. 2'b11 adds an odd parity bit equal to the inverse of that XOR. 2'b00 and 2'b01 add no parity bit. The parity bit sits right after the last data bit.
- R5: After the data bits (and any parity bit) come stop bits of value 1: one stop bit when `cfg_two_stop` is 0, two when it is 1.
- R6: `tx_line` changes only on a clock edge where `bit_tick` is high, so each bit lasts exactly one tick period.
- R7: `in_ready` is high while idle and during the last stop bit, and low during every other bit of a frame. A character accepted in the last stop bit starts its start bit on the next tick, with no idle bit in between.
- R8: When the last stop bit ends and no character is waiting, `busy` falls and `tx_line` stays high.
- R9: Bits of `in_data` above the active data length have no effect on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle bit-period strobe from the baud generator |
| in_valid | input | 1 | A character is offered on `in_data` |
| in_ready | output | 1 | The transmitter can take a character this cycle |
| in_data | input | 9 | Character, right aligned |
| cfg_size | input | 3 | Character size code |
| cfg_parity | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_line | output | 1 | Serial output, high when idle |
| busy | output | 1 | A frame is on the line or a character is waiting |

## Verification
The bench runs frames in all 64 combinations of size code, parity code and stop select, so both reserved codes (sizes 4 to 6 and parity 01) are exercised alongside the 30 legal formats. Each format is sent with all-ones data, which exposes any bit that leaks in above the active length, and with all-zeros data, which separates even parity from odd by a 0 against a 1. A mixed pattern catches swapped or reversed bit order. Back-to-back pairs show whether the second start bit follows the last stop bit directly or after an idle bit. A reset in the middle of a frame shows whether the line drops back to idle at once.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    localparam int MAX_DATA  = 9;
    localparam int MAX_STOP  = 2;
    localparam int FRAME_W   = 1 + MAX_DATA + 1 + MAX_STOP;
    localparam int LEN_W     = $clog2(FRAME_W + 1);
    localparam int NBITS_W   = $clog2(MAX_DATA + 1);
    localparam int SIZE_W    = 3;
    localparam int PAR_W     = 2;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } par_e;

    typedef struct packed {
        logic [NBITS_W-1:0] nbits;
        par_e               par;
        logic               two_stop;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic logic [NBITS_W-1:0] size_to_bits(input logic [SIZE_W-1:0] code);
        logic [NBITS_W-1:0] n;
        case (code)
            3'd0:    n = NBITS_W'(5);
            3'd1:    n = NBITS_W'(6);
            3'd2:    n = NBITS_W'(7);
            3'd3:    n = NBITS_W'(8);
            3'd7:    n = NBITS_W'(9);
            default: n = NBITS_W'(8);
        endcase
        return n;
    endfunction

    function automatic par_e code_to_par(input logic [PAR_W-1:0] code);
        par_e p;
        case (code)
            2'b10:   p = PAR_EVEN;
            2'b11:   p = PAR_ODD;
            default: p = PAR_NONE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sftx_fmt_decode.sv
module sftx_fmt_decode
    import sftx_pkg::*;
(
    input  logic [SIZE_W-1:0] size_code,
    input  logic [PAR_W-1:0]  par_code,
    input  logic              stop_sel,
    output fmt_t              fmt
);
    always_comb begin
        fmt.nbits    = size_to_bits(size_code);
        fmt.par      = code_to_par(par_code);
        fmt.two_stop = stop_sel;
    end
endmodule

// File: rtl/sftx_frame_build.sv
module sftx_frame_build
    import sftx_pkg::*;
(
    input  logic [MAX_DATA-1:0] data,
    input  fmt_t                fmt,
    output frame_t              frame
);
    logic par_bit;
    logic par_on;

    always_comb begin
        par_bit = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(fmt.nbits)) par_bit = par_bit ^ data[i];
        end
        if (fmt.par == PAR_ODD) par_bit = ~par_bit;
        par_on = (fmt.par != PAR_NONE);
    end

    always_comb begin
        frame.bits    = '1;
        frame.bits[0] = 1'b0;
        for (int j = 1; j < FRAME_W; j++) begin
            if (j <= int'(fmt.nbits)) begin
                frame.bits[j] = data[j-1];
            end else if (par_on && j == int'(fmt.nbits) + 1) begin
                frame.bits[j] = par_bit;
            end
        end
        frame.len = LEN_W'(fmt.nbits) + LEN_W'(2) + LEN_W'(par_on) + LEN_W'(fmt.two_stop);
    end
endmodule

// File: rtl/sftx_serializer.sv
module sftx_serializer
    import sftx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load_req,
    input  frame_t load_frame,
    output logic   ready,
    output logic   line,
    output logic   busy
);
    logic [FRAME_W-1:0] sh_q;
    logic [LEN_W-1:0]   left_q;
    logic               act_q;
    frame_t             pend_q;
    logic               pend_v_q;

    logic   last_bit;
    logic   slot_free;
    logic   accept;
    logic   have_next;
    frame_t next_frame;

    always_comb begin
        last_bit   = act_q && (left_q == LEN_W'(1));
        slot_free  = !act_q || last_bit;
        ready      = !pend_v_q && slot_free;
        accept     = load_req && ready;
        have_next  = pend_v_q || accept;
        next_frame = pend_v_q ? pend_q : load_frame;
        line       = act_q ? sh_q[0] : 1'b1;
        busy       = act_q || pend_v_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '1;
            left_q   <= '0;
            act_q    <= 1'b0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (tick && slot_free) begin
            if (have_next) begin
                sh_q     <= next_frame.bits;
                left_q   <= next_frame.len;
                act_q    <= 1'b1;
                pend_v_q <= 1'b0;
            end else begin
                act_q    <= 1'b0;
                sh_q     <= '1;
            end
        end else begin
            if (tick && act_q) begin
                sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                left_q <= left_q - LEN_W'(1);
            end
            if (accept) begin
                pend_q   <= load_frame;
                pend_v_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sftx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_tick,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [MAX_DATA-1:0] in_data,
    input  logic [SIZE_W-1:0]   cfg_size,
    input  logic [PAR_W-1:0]    cfg_parity,
    input  logic                cfg_two_stop,
    output logic                tx_line,
    output logic                busy
);
    fmt_t   fmt;
    frame_t frame;

    sftx_fmt_decode u_dec (
        .size_code (cfg_size),
        .par_code  (cfg_parity),
        .stop_sel  (cfg_two_stop),
        .fmt       (fmt)
    );

    sftx_frame_build u_build (
        .data  (in_data),
        .fmt   (fmt),
        .frame (frame)
    );

    sftx_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .tick       (bit_tick),
        .load_req   (in_valid),
        .load_frame (frame),
        .ready      (in_ready),
        .line       (tx_line),
        .busy       (busy)
    );
endmodule

// File: rtl/sftx_checker.sv
module sftx_checker (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic in_valid,
    input logic in_ready,
    input logic tx_line,
    input logic busy
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (tx_line && !busy && in_ready));

    assert_accept_holds_high_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !busy && !bit_tick) |=> (tx_line && busy));

    assert_line_moves_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(tx_line));

    assert_ready_in_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && in_ready) |-> tx_line);

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tx_line && in_ready));

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy);
endmodule

bind serial_frame_tx sftx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_line  (tx_line),
    .busy     (busy)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_tick;
    logic       in_valid;
    logic [8:0] in_data;
    logic [2:0] cfg_size;
    logic [1:0] cfg_parity;
    logic       cfg_two_stop;
    logic       in_ready;
    logic       tx_line;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;
    int phase = 0;

    always #10 clk = ~clk;

    serial_frame_tx u0 (
        .clk          (clk),
        .rst          (rst),
        .bit_tick     (bit_tick),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .cfg_size     (cfg_size),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .tx_line      (tx_line),
        .busy         (busy)
    );

    task automatic cyc();
        @(negedge clk);
        bit_tick = (phase == TICK_DIV - 1);
        phase    = (phase + 1) % TICK_DIV;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (size=%0d par=%0d stop=%0d data=%h)",
                     req, act, exp, cfg_size, cfg_parity, cfg_two_stop, in_data);
        end
    endtask

    task automatic wait_tick_edge();
        logic t;
        do begin
            t = bit_tick;
            cyc();
        end while (!t);
    endtask

    function automatic int data_len(input logic [2:0] code);
        if (code < 3'd4) return int'(code) + 5;
        if (code == 3'd7) return 9;
        return 8;
    endfunction

    task automatic tx_bits(input logic [8:0] d);
        int  n;
        int  len;
        logic p;
        logic [12:0] exp;
        string tag;
        n   = data_len(cfg_size);
        p   = 1'b0;
        exp = '1;
        exp[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            exp[i+1] = d[i];
            p = p ^ d[i];
        end
        len = n + 1;
        if (cfg_parity[1]) begin
            exp[len] = cfg_parity[0] ? ~p : p;
            len++;
        end
        len = len + (cfg_two_stop ? 2 : 1);
        for (int k = 0; k < len; k++) begin
            wait_tick_edge();
            if (k == 0) tag = "R2 start bit";
            else if (k <= n) tag = ((d >> n) != 0) ? "R3 data bit (R9 upper bits set)" : "R3 data bit";
            else if (cfg_parity[1] && k == n + 1) tag = "R4 parity bit";
            else tag = "R5 stop bit";
            chk(tag, int'(tx_line), int'(exp[k]));
            if (k < len - 1) chk("R7 ready low mid-frame", int'(in_ready), 0);
            else chk("R7 ready in last stop bit", int'(in_ready), 1);
            cyc();
            chk("R6 bit held for tick period", int'(tx_line), int'(exp[k]));
        end
    endtask

    task automatic offer(input logic [8:0] d);
        while (bit_tick) cyc();
        in_valid = 1'b1;
        in_data  = d;
        cyc();
        in_valid = 1'b0;
    endtask

    task automatic idle_check();
        wait_tick_edge();
        chk("R8 line high after frame", int'(tx_line), 1);
        chk("R8 busy low after frame", int'(busy), 0);
    endtask

    task automatic single(input logic [8:0] d);
        chk("R7 ready while idle", int'(in_ready), 1);
        offer(d);
        chk("R2 line high until tick", int'(tx_line), 1);
        chk("R2 busy after accept", int'(busy), 1);
        tx_bits(d);
        idle_check();
    endtask

    task automatic pair(input logic [8:0] a, input logic [8:0] b);
        offer(a);
        tx_bits(a);
        offer(b);
        tx_bits(b);
        idle_check();
    endtask

    initial begin
        rst = 1'b1;
        bit_tick = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        cfg_size = 3'd3;
        cfg_parity = 2'b00;
        cfg_two_stop = 1'b0;
        repeat (4) cyc();
        chk("R1 reset line", int'(tx_line), 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset ready", int'(in_ready), 1);
        rst = 1'b0;
        repeat (3) cyc();

        for (int sz = 0; sz < 8; sz++)
            for (int pm = 0; pm < 4; pm++)
                for (int st = 0; st < 2; st++) begin
                    cfg_size     = 3'(sz);
                    cfg_parity   = 2'(pm);
                    cfg_two_stop = st[0];
                    single(9'h1FF);
                    single(9'h000);
                    single(9'((sz * 53 + pm * 29 + st * 7) ^ 9'h0A5));
                end

        // R7 back-to-back frames with no idle bit between
        for (int sz = 0; sz < 8; sz++) begin
            cfg_size     = 3'(sz);
            cfg_parity   = 2'(sz % 4);
            cfg_two_stop = sz[0];
            pair(9'(9'h13C + sz * 17), 9'(9'h0C3 ^ (sz * 41)));
        end

        // R1 reset in the middle of a frame
        cfg_size = 3'd7; cfg_parity = 2'b11; cfg_two_stop = 1'b1;
        offer(9'h000);
        wait_tick_edge();
        wait_tick_edge();
        rst = 1'b1;
        cyc();
        chk("R1 mid-frame reset line", int'(tx_line), 1);
        chk("R1 mid-frame reset busy", int'(busy), 0);
        chk("R1 mid-frame reset ready", int'(in_ready), 1);
        rst = 1'b0;
        repeat (2) cyc();
        chk("R1 first cycle after reset", int'(tx_line), 1);
        single(9'h0F0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule